// File: doc/BRIEF.md
# Banked 4x4 Block-Read Tile Buffer

This block is an on-chip image tile store. It holds a square image of `DIM` by `DIM` data words, and a whole 4x4 block of words can be fetched from it in one clock cycle. The deployment size is 256 by 256; the parameter defaults are smaller so that elaboration stays light. The words live in 64 small, independent RAM banks. Each bank has one write port and one registered read port, so each one maps onto plain inferred block RAM.

A loader fills the buffer from a valid/ready word stream. A load command carries a start position, a row stride and a row count. The loader then accepts `SEG` consecutive words per row segment. After each segment it steps down by the stride and starts the next segment at the same starting column.

The read side takes a block coordinate and returns sixteen words in row-major order one cycle later. A padded mode shifts the window one row up and one column left, so that a 3x3 neighbourhood operator sees a zero border. Elements outside the image then read as zero.

Top module: `tbb_top`

## Requirements
- R1: On a read without padding, output element (i,j) at bits `[(4*i+j)*DW +: DW]` of `rd_data` equals the word stored at row `4*rd_brow+i`, column `4*rd_bcol+j`, for i,j in 0..3.
- R2: `rd_valid` is high in exactly the cycle after a cycle with `rd_en` high, and `rd_data` is valid in that cycle.
- R3: With `rd_pad` high, element (i,j) comes from row `4*rd_brow+i-1`, column `4*rd_bcol+j-1`. Any element whose row or column falls outside 0..DIM-1 reads as zero.
- R4: The word at (r,c) is stored in bank `{r mod 4, q, c mod 4}` (6 bits, row bits highest). Here q is 0, 3, 2, 1 for column group `(c/4) mod 4` equal to 0, 1, 2, 3. The sixteen elements of any read window fall into sixteen distinct banks.
- R5: A load starts when `ld_start` is high while idle and `ld_rows` is non-zero. The start row is `ld_block[15:8]` and the start column is `ld_block[7:0]`, each taken modulo DIM. Word k (0..SEG-1) of segment m goes to row `(row0 + m*ld_stride) mod DIM`, column `(col0 + k) mod DIM`.
- R6: `s_ready` is high from the cycle after an accepted start until `ld_rows*SEG` words have been accepted, and low after that.
- R7: `ld_start` while a load is in progress is ignored: the running load keeps its parameters and ends on its own count.
- R8: `ld_start` with `ld_rows` equal to zero starts nothing, and `s_ready` stays low.
- R9: After reset, `rd_valid` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_start | input | 1 | Start a load command |
| ld_stride | input | 8 | Row step between segments |
| ld_rows | input | 8 | Number of segments to load |
| ld_block | input | 16 | Start position: row in [15:8], column in [7:0] |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Loader accepts a word |
| rd_en | input | 1 | Block read request |
| rd_pad | input | 1 | Padded window mode |
| rd_brow | input | AW-2 | Block row coordinate |
| rd_bcol | input | AW-2 | Block column coordinate |
| rd_valid | output | 1 | Block data valid |
| rd_data | output | 16*DW | Sixteen words, row-major |

## Verification
The hardest case to reach is a padded window at the image edges. There the window straddles two column groups in different bank quads, and some elements leave the image while others wrap to far banks. The scoreboard covers it by sweeping every block coordinate in both modes after each load. Loads use odd strides and column wrap, so neighbouring groups hold unrelated data and a misrouted crossbar lane cannot return a plausible value. Ignored and empty starts are injected in the middle of, or in place of, a load, and the effect is observed at `s_ready` and through the full read sweep.

// File: rtl/tbb_pkg.sv
package tbb_pkg;
  localparam int NBANK = 64;
  localparam int NELEM = 16;
  typedef logic [5:0] bank_t;

  // rotating placement of column groups onto bank quads
  function automatic logic [1:0] quad_of(input logic [1:0] grp);
    return 2'(3'd4 - {1'b0, grp});
  endfunction
endpackage

// File: rtl/tbb_bank.sv
module tbb_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int BAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [BAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [BAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tbb_loader.sv
module tbb_loader #(
  parameter int DW  = 16,
  parameter int DIM = 32,
  parameter int SEG = 16,
  localparam int AW  = $clog2(DIM),
  localparam int SCW = $clog2(SEG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    stride,
  input  logic [7:0]    rows,
  input  logic [15:0]   block,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_row,
  output logic [AW-1:0] wr_col,
  output logic [DW-1:0] wr_data
);
  logic          busy;
  logic [AW-1:0] row, col, col0, strd;
  logic [7:0]    left;
  logic [SCW-1:0] segc;
  logic          seg_last;

  assign seg_last = (segc == SCW'(SEG - 1));
  assign s_ready  = busy;
  assign wr_en    = busy & s_valid;
  assign wr_row   = row;
  assign wr_col   = col;
  assign wr_data  = s_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
      col0 <= '0;
      strd <= '0;
      left <= '0;
      segc <= '0;
    end else if (!busy) begin
      if (start && rows != 8'd0) begin
        busy <= 1'b1;
        row  <= block[8 +: AW];
        col  <= block[0 +: AW];
        col0 <= block[0 +: AW];
        strd <= stride[AW-1:0];
        left <= rows;
        segc <= '0;
      end
    end else if (s_valid) begin
      if (seg_last) begin
        segc <= '0;
        col  <= col0;
        row  <= row + strd;
        left <= left - 8'd1;
        if (left == 8'd1) busy <= 1'b0;
      end else begin
        segc <= segc + 1'b1;
        col  <= col + 1'b1;
      end
    end
  end

  // R6
  load_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(s_valid && seg_last && left == 8'd1));
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start |=> $stable(strd) && $stable(col0));
  // R8
  empty_start_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && start && rows == 8'd0 |=> !busy);
endmodule

// File: rtl/tbb_top.sv
module tbb_top #(
  parameter int DW  = 16,
  parameter int DIM = 32,
  parameter int SEG = 16,
  localparam int AW  = $clog2(DIM),
  localparam int BW  = AW - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_start,
  input  logic [7:0]        ld_stride,
  input  logic [7:0]        ld_rows,
  input  logic [15:0]       ld_block,
  input  logic              s_valid,
  input  logic [DW-1:0]     s_data,
  output logic              s_ready,
  input  logic              rd_en,
  input  logic              rd_pad,
  input  logic [BW-1:0]     rd_brow,
  input  logic [BW-1:0]     rd_bcol,
  output logic              rd_valid,
  output logic [16*DW-1:0]  rd_data
);
  import tbb_pkg::*;

  localparam int DEPTH = DIM * DIM / NBANK;
  localparam int BAW   = $clog2(DEPTH);

  logic          wr_en;
  logic [AW-1:0] wr_row, wr_col;
  logic [DW-1:0] wr_data;
  bank_t         wbank;
  logic [BAW-1:0] waddr;
  logic          unused_blk;

  assign unused_blk = ^{ld_block, ld_stride};

  tbb_loader #(.DW(DW), .DIM(DIM), .SEG(SEG)) i_loader (
    .clk(clk), .rst(rst), .start(ld_start), .stride(ld_stride),
    .rows(ld_rows), .block(ld_block), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data)
  );

  assign wbank = {wr_row[1:0], quad_of(wr_col[3:2]), wr_col[1:0]};
  assign waddr = {wr_row[AW-1:2], wr_col[AW-1:4]};

  // per-element coordinates, bank and in-bank address
  logic [AW:0]    er [NELEM];
  logic [AW:0]    ec [NELEM];
  bank_t          ebank [NELEM];
  logic [BAW-1:0] eaddr [NELEM];
  logic [NELEM-1:0] eout;
  logic [BAW-1:0] raddr [NBANK];
  logic [NBANK-1:0] hit;

  always_comb begin
    for (int e = 0; e < NELEM; e++) begin
      er[e] = {1'b0, rd_brow, 2'b00} + (AW+1)'(e / 4) - (AW+1)'(rd_pad);
      ec[e] = {1'b0, rd_bcol, 2'b00} + (AW+1)'(e % 4) - (AW+1)'(rd_pad);
      eout[e]  = er[e][AW] | ec[e][AW];
      ebank[e] = {er[e][1:0], quad_of(ec[e][3:2]), ec[e][1:0]};
      eaddr[e] = {er[e][AW-1:2], ec[e][AW-1:4]};
    end
  end

  always_comb begin
    hit = '0;
    for (int e = 0; e < NELEM; e++) hit[ebank[e]] = 1'b1;
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      raddr[b] = '0;
      for (int e = 0; e < NELEM; e++)
        if (ebank[e] == bank_t'(b)) raddr[b] = eaddr[e];
    end
  end

  logic [DW-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    tbb_bank #(.DW(DW), .DEPTH(DEPTH)) i_bank (
      .clk(clk), .we(wr_en && wbank == bank_t'(b)), .waddr(waddr),
      .wdata(wr_data), .raddr(raddr[b]), .rdata(bank_q[b])
    );
  end

  bank_t            ebank_q [NELEM];
  logic [NELEM-1:0] zero_q;
  logic             pad_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      zero_q   <= '0;
      pad_q    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      zero_q   <= eout;
      pad_q    <= rd_pad;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NELEM; e++) ebank_q[e] <= ebank[e];
  end

  // output crossbar: bank outputs back to row-major lanes
  always_comb begin
    for (int e = 0; e < NELEM; e++)
      rd_data[e*DW +: DW] = zero_q[e] ? '0 : bank_q[ebank_q[e]];
  end

  // R2
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  // R4
  bank_unique_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> $countones(hit) == NELEM);
  // R3
  unpad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !pad_q |-> zero_q == '0);
endmodule

// File: tb/test_tbb_top.sv
module test_tbb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int DIM = 32;
  localparam int SEG = 16;
  localparam int AW  = $clog2(DIM);
  localparam int BW  = AW - 2;
  localparam int NB  = DIM / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_start = 1'b0;
  logic [7:0] ld_stride = '0, ld_rows = '0;
  logic [15:0] ld_block = '0;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready;
  logic rd_en = 1'b0, rd_pad = 1'b0;
  logic [BW-1:0] rd_brow = '0, rd_bcol = '0;
  logic rd_valid;
  logic [16*DW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] refm [DIM][DIM];
  logic [16*DW-1:0] expq [$];
  string tagq [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbb_top #(.DW(DW), .DIM(DIM), .SEG(SEG)) i_tbb_top (
    .clk(clk), .rst(rst), .ld_start(ld_start), .ld_stride(ld_stride),
    .ld_rows(ld_rows), .ld_block(ld_block), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .rd_en(rd_en), .rd_pad(rd_pad),
    .rd_brow(rd_brow), .rd_bcol(rd_bcol), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic check1(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  // monitor: pops expected blocks as the design returns them (R1, R2, R3)
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: rd_valid with no read pending, got 1 expected 0");
      end else begin
        logic [16*DW-1:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        checks++;
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  // driver: one block read per cycle, expected value pushed at issue
  task automatic rd_block(int br, int bc, bit pad);
    logic [16*DW-1:0] e;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        int r, c;
        r = 4*br + i - int'(pad);
        c = 4*bc + j - int'(pad);
        if (r < 0 || c < 0 || r >= DIM || c >= DIM) e[(4*i+j)*DW +: DW] = '0;
        else e[(4*i+j)*DW +: DW] = refm[r][c];
      end
    expq.push_back(e);
    tagq.push_back($sformatf("%s blk(%0d,%0d)", pad ? "R3" : "R1", br, bc));
    rd_en = 1'b1; rd_pad = pad;
    rd_brow = BW'(br); rd_bcol = BW'(bc);
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int p = 0; p < 2; p++)
      for (int br = 0; br < NB; br++)
        for (int bc = 0; bc < NB; bc++) rd_block(br, bc, p[0]);
    rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // R5: load with a data pattern; inj >= 0 pulses a start mid-load (R7)
  task automatic do_load(int stride, int rows, int blk, int seed, int inj);
    int row0, col0, n;
    row0 = (blk >> 8) % DIM;
    col0 = (blk & 255) % DIM;
    ld_start = 1'b1; ld_stride = 8'(stride); ld_rows = 8'(rows);
    ld_block = 16'(blk);
    @(negedge clk);
    ld_start = 1'b0;
    n = 0;
    for (int m = 0; m < rows; m++)
      for (int k = 0; k < SEG; k++) begin
        logic [DW-1:0] d;
        d = DW'(seed * 4099 + m * 263 + k * 37 + n * 5);
        s_valid = 1'b1; s_data = d;
        if (n == inj) begin
          ld_start = 1'b1; ld_stride = 8'd1; ld_rows = 8'd9; ld_block = 16'h0000;
        end
        while (!s_ready) @(negedge clk);
        refm[(row0 + m*stride) % DIM][(col0 + k) % DIM] = d;
        @(negedge clk);
        ld_start = 1'b0;
        s_valid = 1'b0;
        n++;
      end
    check1("R6 s_ready after last word", s_ready, 1'b0);
    @(negedge clk);
    check1(inj >= 0 ? "R7 no restart" : "R6 idle", s_ready, 1'b0);
  endtask

  initial begin
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++) refm[r][c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check1("R9 rd_valid", rd_valid, 1'b0);
    check1("R9 s_ready", s_ready, 1'b0);

    // fill the whole image in two column halves
    do_load(1, DIM, 16'h0000, 1, -1);
    do_load(1, DIM, 16'h0010, 2, -1);
    sweep();

    // odd stride, partial rows
    do_load(3, 5, 16'h0208, 3, -1);
    sweep();

    // row and column wrap, start injected mid-load (R7)
    do_load(7, 3, 16'h1E18, 4, 20);
    sweep();

    // R8: empty start
    ld_start = 1'b1; ld_rows = 8'd0; ld_block = 16'h0000;
    @(negedge clk);
    ld_start = 1'b0;
    @(negedge clk);
    check1("R8 no load", s_ready, 1'b0);
    s_valid = 1'b1; s_data = 16'hDEAD;
    repeat (3) @(negedge clk);
    s_valid = 1'b0;
    sweep();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule